// File: doc/BRIEF.md
# Dithered Serial Bit-Period Timer

This block paces a serializer. For each transaction it emits one `bit_tick` strobe at the end of every bit period. With dithering enabled, the length of each bit period moves up or down from a nominal cycle count by a pseudo-random sign. The whole frame still lasts exactly the nominal length.

The pseudo-random source is a linear feedback shift register. A 2-bit field selects its length (6, 7, 11 or 15 stages) and, with it, the feedback tap pair. Bits are dithered in pairs. The first bit of a pair is stretched or squeezed by the deviation amount, and its partner takes the opposite offset, so each pair costs two nominal periods.

A six-bit control register holds:
- an enable,
- a freeze bit,
- the length select,
- a deviation amount of 0 to 3 cycles.

While the freeze bit is set, the frequency offset register ignores writes. The control settings are captured when a transaction starts. Any control write cancels a transaction that is running.

Top module: `bit_dither`

## Requirements
- R1: After reset the control register (`cfg_q`) and the offset register (`ofs_q`) read 0. `frame_busy`, `bit_tick` and `frame_done` are low, and no tick or done appears while no frame runs.
- R2: When the captured enable bit (`cfg_q[0]`) is 0, every bit period is exactly `NOM_CYC` cycles. The shift register keeps its state, so a later enabled frame with the same length select continues the same sequence.
- R3: The length select `cfg_q[3:2]` picks the following register length and taps:

  | Select | Length | Taps |
  |--------|--------|------|
  | 2'b00 | 11 | bits 10 and 8 |
  | 2'b01 | 15 | bits 14 and 13 |
  | 2'b10 | 6 | bits 5 and 4 |
  | 2'b11 | 7 | bits 6 and 5 |

  Each step computes `s' = {s[L-2:0], s[ta]^s[tb]}`. The step takes place once, when the first bit of a pair is loaded with dithering enabled, and the sign bit is `s[0]` from before that step.
- R4: With deviation `d = cfg_q[5:4]`, each bit pair starts at bit index 0, 2, 4 and so on.
  - Sign bit 1: the pair's first bit lasts `NOM_CYC+d` cycles and its partner lasts `NOM_CYC-d` cycles.
  - Sign bit 0: the pair's first bit lasts `NOM_CYC-d` cycles and its partner lasts `NOM_CYC+d` cycles.
  - Odd frame length: the unpaired last bit lasts `NOM_CYC` cycles.
- R5: A frame of N bits gives exactly N ticks. The last tick comes exactly `N*NOM_CYC` cycles after the start edge, with `frame_done` high together with it and with no other tick.
- R6: The shift register holds all ones (of the selected length) after reset. It is reloaded with all ones when a frame starts with a length select different from the previous frame's, so that frame's first pair starts with a lengthened bit.
- R7: A control write while a frame runs aborts it. `frame_busy` is low from the next cycle, and no further tick or done follows. A frame start in the same cycle as a control write is ignored.
- R8: Control writes made while idle take effect from the next frame start.
- R9: While the freeze bit `cfg_q[1]` is 1, writes to the offset register leave `ofs_q` unchanged. While it is 0, a write loads `ofs_q` on the next cycle.
- R10: A frame start while a frame runs is ignored and does not disturb the running frame.
- R11: A frame start with a bit count of 0 is ignored, and `frame_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control write data {dev[1:0], len_sel[1:0], freeze, enable} |
| cfg_q | output | 6 | Control register contents |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_wdata | input | OFS_W | Offset write data |
| ofs_q | output | OFS_W | Offset register contents |
| frame_start | input | 1 | Starts a transaction when idle |
| frame_bits | input | BITS_W | Number of bits in the transaction |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit period |
| frame_busy | output | 1 | A transaction is running |
| frame_done | output | 1 | High with the last tick of a transaction |

## Verification
A wrong shift register state shows up at the ports within one bit pair. The first tick of the pair arrives `2*d` cycles early or late, and the partner tick then lands back on the nominal grid. The bench times every tick interval against its own register model, across many frames, so a wrong tap, length or step condition is reported at the first pair whose sign differs. A lost or repeated offset in the pairing moves every later tick and the frame-end total, and the frame-end total is checked on every frame.

// File: rtl/dither_pkg.sv
package dither_pkg;

   localparam int PRBS_W = 15;

   typedef struct packed {
      logic [1:0] dev;
      logic [1:0] len_sel;
      logic       freeze;
      logic       en;
   } dither_cfg_t;

   function automatic int prbs_len(input logic [1:0] sel);
      case (sel)
         2'b00:   return 11;
         2'b01:   return 15;
         2'b10:   return 6;
         default: return 7;
      endcase
   endfunction

   function automatic int prbs_tap_a(input logic [1:0] sel);
      return prbs_len(sel) - 1;
   endfunction

   function automatic int prbs_tap_b(input logic [1:0] sel);
      case (sel)
         2'b00:   return 8;
         2'b01:   return 13;
         2'b10:   return 4;
         default: return 5;
      endcase
   endfunction

endpackage

// File: rtl/dither_prbs.sv
module dither_prbs #(
   parameter int W = dither_pkg::PRBS_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed,
   input  logic         step,
   input  logic [1:0]   sel,
   output logic [W-1:0] cur
);
   import dither_pkg::*;

   localparam logic [W-1:0] ONES  = {W{1'b1}};
   localparam logic [W-1:0] SEED0 = ONES >> (W - prbs_len(2'b00));

   logic [W-1:0] mask_v [4];
   logic         fb_v   [4];
   logic [W-1:0] q;
   logic [W-1:0] nxt;

   for (genvar g = 0; g < 4; g++) begin : g_len
      if (prbs_len(2'(g)) > W) begin : g_bad
         $error("dither_prbs: W too small for length select %0d", g);
      end
      assign mask_v[g] = ONES >> (W - prbs_len(2'(g)));
      assign fb_v[g]   = cur[prbs_tap_a(2'(g))] ^ cur[prbs_tap_b(2'(g))];
   end

   assign cur = seed ? mask_v[sel] : q;

   always_comb begin
      nxt = cur;
      if (step) nxt = {cur[W-2:0], fb_v[sel]} & mask_v[sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED0;
      else        q <= nxt;
   end
endmodule

// File: rtl/dither_period.sv
module dither_period #(
   parameter int NOM_CYC = 8,
   parameter int PER_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             first,
   input  logic             partner,
   input  logic             en,
   input  logic [1:0]       dev,
   input  logic             sign,
   output logic [PER_W-1:0] period,
   output logic             step
);
   localparam logic [PER_W-1:0] NOM = PER_W'(NOM_CYC);

   logic       pend_long;
   logic [1:0] pend_d;
   logic       dither_on;

   assign dither_on = first & partner & en;
   assign step      = load & dither_on;

   always_comb begin
      if (first) begin
         if (dither_on) period = sign ? NOM + PER_W'(dev) : NOM - PER_W'(dev);
         else           period = NOM;
      end else begin
         period = pend_long ? NOM - PER_W'(pend_d) : NOM + PER_W'(pend_d);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_long <= 1'b0;
         pend_d    <= 2'd0;
      end else if (load && first) begin
         pend_long <= dither_on & sign;
         pend_d    <= dither_on ? dev : 2'd0;
      end
   end
endmodule

// File: rtl/dither_timer.sv
module dither_timer #(
   parameter int BITS_W = 6,
   parameter int PER_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [BITS_W-1:0] nbits,
   input  logic [PER_W-1:0]  period,
   output logic              launch,
   output logic              load,
   output logic              first,
   output logic              partner,
   output logic              busy,
   output logic              tick,
   output logic              done
);
   logic [PER_W-1:0]  cnt;
   logic [BITS_W-1:0] rem;
   logic              odd;
   logic              last;

   assign launch  = start & ~busy & ~abort & (nbits != '0);
   assign tick    = busy & (cnt == '0);
   assign last    = (rem == BITS_W'(1));
   assign done    = tick & last;
   assign load    = launch | (tick & ~last & ~abort);
   assign first   = launch | odd;
   assign partner = launch ? (nbits >= BITS_W'(2)) : (rem >= BITS_W'(3));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         rem  <= '0;
         odd  <= 1'b0;
      end else if (abort) begin
         busy <= 1'b0;
      end else if (launch) begin
         busy <= 1'b1;
         cnt  <= period - PER_W'(1);
         rem  <= nbits;
         odd  <= 1'b0;
      end else if (tick) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            rem <= rem - BITS_W'(1);
            odd <= ~odd;
            cnt <= period - PER_W'(1);
         end
      end else if (busy) begin
         cnt <= cnt - PER_W'(1);
      end
   end
endmodule

// File: rtl/bit_dither.sv
module bit_dither #(
   parameter int NOM_CYC = 8,
   parameter int BITS_W  = 6,
   parameter int OFS_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_wdata,
   output logic [5:0]        cfg_q,
   input  logic              ofs_we,
   input  logic [OFS_W-1:0]  ofs_wdata,
   output logic [OFS_W-1:0]  ofs_q,
   input  logic              frame_start,
   input  logic [BITS_W-1:0] frame_bits,
   output logic              bit_tick,
   output logic              frame_busy,
   output logic              frame_done
);
   import dither_pkg::*;

   localparam int MAX_DEV = 3;
   localparam int PER_W   = $clog2(NOM_CYC + MAX_DEV + 1);

   if (NOM_CYC <= MAX_DEV) begin : g_bad_nom
      $error("bit_dither: NOM_CYC must exceed the largest deviation");
   end
   if (BITS_W < 2) begin : g_bad_bits
      $error("bit_dither: BITS_W must be at least 2");
   end
   if (OFS_W < 1) begin : g_bad_ofs
      $error("bit_dither: OFS_W must be positive");
   end

   dither_cfg_t       cfg_r;
   logic              act_en;
   logic [1:0]        act_dev;
   logic [1:0]        act_len;
   logic [OFS_W-1:0]  ofs_r;

   logic              launch_w, load_w, first_w, partner_w, step_w, seed_w;
   logic              en_e;
   logic [1:0]        dev_e, len_e;
   logic [PER_W-1:0]  period_w;
   logic [PRBS_W-1:0] prbs_cur;

   assign en_e   = launch_w ? cfg_r.en      : act_en;
   assign dev_e  = launch_w ? cfg_r.dev     : act_dev;
   assign len_e  = launch_w ? cfg_r.len_sel : act_len;
   assign seed_w = launch_w & (cfg_r.len_sel != act_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_r <= '0;
         ofs_r <= '0;
      end else begin
         if (cfg_we)                   cfg_r <= dither_cfg_t'(cfg_wdata);
         if (ofs_we && !cfg_r.freeze)  ofs_r <= ofs_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en  <= 1'b0;
         act_dev <= 2'd0;
         act_len <= 2'd0;
      end else if (launch_w) begin
         act_en  <= cfg_r.en;
         act_dev <= cfg_r.dev;
         act_len <= cfg_r.len_sel;
      end
   end

   dither_timer #(.BITS_W(BITS_W), .PER_W(PER_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (frame_start),
      .abort   (cfg_we),
      .nbits   (frame_bits),
      .period  (period_w),
      .launch  (launch_w),
      .load    (load_w),
      .first   (first_w),
      .partner (partner_w),
      .busy    (frame_busy),
      .tick    (bit_tick),
      .done    (frame_done)
   );

   dither_period #(.NOM_CYC(NOM_CYC), .PER_W(PER_W)) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_w),
      .first   (first_w),
      .partner (partner_w),
      .en      (en_e),
      .dev     (dev_e),
      .sign    (prbs_cur[0]),
      .period  (period_w),
      .step    (step_w)
   );

   dither_prbs #(.W(PRBS_W)) u_prbs (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (seed_w),
      .step  (step_w),
      .sel   (len_e),
      .cur   (prbs_cur)
   );

   assign cfg_q = cfg_r;
   assign ofs_q = ofs_r;
endmodule

// File: rtl/dither_chk.sv
module dither_chk #(
   parameter int NOM_CYC = 8,
   parameter int OFS_W   = 8,
   parameter int PER_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [5:0]       cfg_q,
   input logic             ofs_we,
   input logic [OFS_W-1:0] ofs_wdata,
   input logic [OFS_W-1:0] ofs_q,
   input logic             bit_tick,
   input logic             frame_busy,
   input logic             frame_done,
   input logic             ld,
   input logic             en_e,
   input logic [PER_W-1:0] ld_period
);
   // R1: quiet outputs while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_busy |-> (!bit_tick && !frame_done));

   // R2: disabled dither loads only nominal periods
   a_r2_nominal: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !en_e) |-> (ld_period == PER_W'(NOM_CYC)));

   // R4: loaded period stays within the deviation window
   a_r4_period_window: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (ld_period >= PER_W'(NOM_CYC - 3) && ld_period <= PER_W'(NOM_CYC + 3)));

   // R5: frame end coincides with a tick
   a_r5_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> bit_tick);

   // R7: control write cancels the running frame
   a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && cfg_we) |=> (!frame_busy && !bit_tick));

   // R9: frozen offset register ignores writes
   a_r9_ofs_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_we && cfg_q[1]) |=> $stable(ofs_q));

   // R9: unfrozen offset register takes the write
   a_r9_ofs_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_we && !cfg_q[1]) |=> (ofs_q == $past(ofs_wdata)));
endmodule

bind bit_dither dither_chk #(.NOM_CYC(NOM_CYC), .OFS_W(OFS_W), .PER_W(PER_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_q      (cfg_q),
   .ofs_we     (ofs_we),
   .ofs_wdata  (ofs_wdata),
   .ofs_q      (ofs_q),
   .bit_tick   (bit_tick),
   .frame_busy (frame_busy),
   .frame_done (frame_done),
   .ld         (load_w),
   .en_e       (en_e),
   .ld_period  (period_w)
);

// File: tb/tb_bit_dither.sv
`timescale 1ns/1ps
module tb_bit_dither;
   localparam int NOM    = 8;
   localparam int BITS_W = 6;
   localparam int OFS_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [5:0]        cfg_wdata = '0;
   logic [5:0]        cfg_q;
   logic              ofs_we = 1'b0;
   logic [OFS_W-1:0]  ofs_wdata = '0;
   logic [OFS_W-1:0]  ofs_q;
   logic              frame_start = 1'b0;
   logic [BITS_W-1:0] frame_bits = '0;
   logic              bit_tick, frame_busy, frame_done;

   always #2 clk = ~clk;

   bit_dither #(.NOM_CYC(NOM), .BITS_W(BITS_W), .OFS_W(OFS_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .ofs_we(ofs_we), .ofs_wdata(ofs_wdata), .ofs_q(ofs_q),
      .frame_start(frame_start), .frame_bits(frame_bits),
      .bit_tick(bit_tick), .frame_busy(frame_busy), .frame_done(frame_done));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int b_en = 0, b_frz = 0, b_len = 0, b_dev = 0;
   logic [14:0] m_state;
   int m_len;
   int exp_p [64];
   int got_first;

   task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic int m_len_of(input int sel);
      case (sel)
         0: return 11;
         1: return 15;
         2: return 6;
         default: return 7;
      endcase
   endfunction

   function automatic logic [14:0] m_mask(input int sel);
      return 15'h7FFF >> (15 - m_len_of(sel));
   endfunction

   function automatic logic [14:0] m_step(input logic [14:0] s, input int sel);
      int ta, tb;
      ta = m_len_of(sel) - 1;
      case (sel)
         0: tb = 8;
         1: tb = 13;
         2: tb = 4;
         default: tb = 5;
      endcase
      return {s[13:0], s[ta] ^ s[tb]} & m_mask(sel);
   endfunction

   // R3 R4 R6: expected periods for one frame, advancing the model
   task automatic model_frame(input int n);
      int pend;
      pend = NOM;
      if (b_len != m_len) begin
         m_state = m_mask(b_len);
         m_len   = b_len;
      end
      for (int k = 0; k < n; k++) begin
         if (k % 2 == 0) begin
            if (k + 1 < n && b_en != 0) begin
               if (m_state[0]) begin
                  exp_p[k] = NOM + b_dev; pend = NOM - b_dev;
               end else begin
                  exp_p[k] = NOM - b_dev; pend = NOM + b_dev;
               end
               m_state = m_step(m_state, b_len);
            end else begin
               exp_p[k] = NOM; pend = NOM;
            end
         end else begin
            exp_p[k] = pend;
         end
      end
   endtask

   task automatic wr_cfg(input int en, input int frz, input int len, input int dev);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {2'(dev), 2'(len), 1'(frz), 1'(en)};
      @(negedge clk);
      cfg_we = 1'b0;
      b_en = en; b_frz = frz; b_len = len; b_dev = dev;
      check(cfg_q == {2'(dev), 2'(len), 1'(frz), 1'(en)}, "R8", int'(cfg_q),
            int'({2'(dev), 2'(len), 1'(frz), 1'(en)}), "cfg readback");
   endtask

   task automatic run_frame(input int n, input int inject_at, input string tag);
      int c, last, k;
      model_frame(n);
      @(negedge clk);
      frame_start = 1'b1;
      frame_bits  = BITS_W'(n);
      c = 0; last = 0; k = 0;
      while (k < n && c < n * NOM + 20) begin
         @(negedge clk);
         c++;
         frame_start = (c == inject_at);
         if (bit_tick) begin
            if (k == 0) got_first = c - last;
            check((c - last) == exp_p[k], tag, c - last, exp_p[k], $sformatf("bit %0d period", k));
            check(frame_done == (k == n - 1), "R5", int'(frame_done), int'(k == n - 1), "done flag");
            last = c;
            k++;
         end
      end
      frame_start = 1'b0;
      check(k == n, "R5", k, n, "tick count");
      check(last == n * NOM, "R5", last, n * NOM, "frame length");
      @(negedge clk);
      check(!frame_busy && !bit_tick, "R5", int'(frame_busy), 0, "idle after frame");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      int n, tick_seen;
      void'($urandom(32'd2024));
      m_state = m_mask(0);
      m_len   = 0;
      repeat (3) @(negedge clk);
      check(cfg_q == 6'd0, "R1", int'(cfg_q), 0, "cfg after reset");
      check(ofs_q == '0, "R1", int'(ofs_q), 0, "ofs after reset");
      check(!frame_busy && !bit_tick && !frame_done, "R1", int'(frame_busy), 0, "idle during reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!frame_busy && !bit_tick, "R1", int'(bit_tick), 0, "idle after reset");

      // R9: offset write lock
      wr_cfg(0, 1, 0, 0);
      ofs_we = 1'b1; ofs_wdata = 8'hA5;
      @(negedge clk); ofs_we = 1'b0;
      @(negedge clk);
      check(ofs_q == 8'h00, "R9", int'(ofs_q), 0, "frozen offset");
      wr_cfg(0, 0, 0, 0);
      ofs_we = 1'b1; ofs_wdata = 8'h3C;
      @(negedge clk); ofs_we = 1'b0;
      check(ofs_q == 8'h3C, "R9", int'(ofs_q), 'h3C, "unfrozen offset");

      // R6: first frame after reset uses all-ones seed of 11 bits
      wr_cfg(1, 0, 0, 3);
      run_frame(6, 0, "R6");
      check(got_first == NOM + 3, "R6", got_first, NOM + 3, "seeded first bit long");

      // R2: disabled frame, then continuation of same sequence
      wr_cfg(0, 0, 0, 3);
      run_frame(9, 0, "R2");
      wr_cfg(1, 0, 0, 2);
      run_frame(8, 0, "R2");

      // R6: length change reseeds
      wr_cfg(1, 0, 2, 2);
      run_frame(4, 0, "R6");
      check(got_first == NOM + 2, "R6", got_first, NOM + 2, "reseed first bit long");

      // R4: odd frame, last bit nominal
      wr_cfg(1, 0, 3, 1);
      run_frame(7, 0, "R4");
      run_frame(1, 0, "R4");

      // R10: start while busy ignored
      wr_cfg(1, 0, 1, 3);
      run_frame(5, NOM + 3, "R10");

      // R3 R4 R5: random frames
      for (int i = 0; i < 40; i++) begin
         wr_cfg(($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 4);
         n = 1 + ($urandom % 30);
         run_frame(n, 0, "R3");
      end

      // R7: abort by control write
      wr_cfg(1, 0, 0, 1);
      model_frame(10);
      @(negedge clk);
      frame_start = 1'b1; frame_bits = BITS_W'(10);
      @(negedge clk);
      frame_start = 1'b0;
      repeat (NOM + 1) @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = {2'd2, 2'd3, 1'b0, 1'b1};
      @(negedge clk);
      cfg_we = 1'b0;
      b_en = 1; b_frz = 0; b_len = 3; b_dev = 2;
      check(!frame_busy, "R7", int'(frame_busy), 0, "busy after abort");
      tick_seen = 0;
      repeat (40) begin
         @(negedge clk);
         if (bit_tick || frame_done || frame_busy) tick_seen++;
      end
      check(tick_seen == 0, "R7", tick_seen, 0, "activity after abort");
      // model resyncs: length 3 differs from aborted frame's 0, so reseed
      run_frame(6, 0, "R6");

      // R7: start together with a control write is ignored
      @(negedge clk);
      frame_start = 1'b1; frame_bits = BITS_W'(4);
      cfg_we = 1'b1; cfg_wdata = {2'd1, 2'd3, 1'b0, 1'b1};
      @(negedge clk);
      frame_start = 1'b0; cfg_we = 1'b0;
      b_dev = 1;
      check(!frame_busy, "R7", int'(frame_busy), 0, "start with write");

      // R11: zero bit count ignored
      @(negedge clk);
      frame_start = 1'b1; frame_bits = '0;
      @(negedge clk);
      frame_start = 1'b0;
      tick_seen = 0;
      repeat (20) begin
         @(negedge clk);
         if (frame_busy || bit_tick) tick_seen++;
      end
      check(tick_seen == 0, "R11", tick_seen, 0, "zero-length start");

      // R8: idle write applies on next frame
      run_frame(10, 0, "R8");

      summary();
   end
endmodule